// File: doc/BRIEF.md
# Buffered BCD Real-Time Clock Core

This block keeps calendar time in 24-hour packed BCD: seconds, minutes, hours, day of the week, date, month and two-digit year. An internal counter chain advances once for each pulse on a 1 Hz tick input. Software never reads those counters directly. It sees a second, visible register set that normally follows the counters one clock behind. Software uses the register interface to write a control word and to read or write the visible registers.

Two control bits change how the visible set behaves. The read-freeze bit captures the count and holds it, so a multi-byte read is coherent while the counters keep running. The write-freeze bit also holds the visible set, and it opens the visible set to software writes. When software clears write-freeze, all visible values are copied into the counters in one clock edge. A separate oscillator-stop bit sits in the top bit of the seconds register. It gates the 1 Hz tick, and it comes out of reset set.

A small state machine owns the visible set. It has four states:

- **TRACK** copies the counters every cycle.
- **RD_HOLD** is frozen for reading.
- **WR_HOLD** is frozen and writable.
- **RESYNC** holds until the next raw tick after every freeze bit has cleared.

Its transitions are:

- **TRACK→RD_HOLD / TRACK→WR_HOLD** on a control write that sets a freeze bit. The count is captured in the same cycle.
- **RD_HOLD→WR_HOLD** when write-freeze is set.
- **RD_HOLD→RESYNC** when read-freeze is cleared.
- **WR_HOLD→RESYNC / WR_HOLD→RD_HOLD** on a commit, depending on the read bit written with it.
- **RESYNC→RD_HOLD / RESYNC→WR_HOLD** on a new freeze, with capture.
- **RESYNC→TRACK** on a tick.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the oscillator-stop bit is 1, the control word reads 0x00, and the time reads 00:00:00, with day 1, date 1, month 1 and year 00.
- R2: The oscillator-stop bit is bit 7 of register 1, and a write to register 1 updates it in any state. While it is 1, ticks are ignored and no counter changes. While it is 0, each tick advances the count by one second.
- R3: Seconds and minutes count 00 to 59, and hours count 00 to 23. Each carries into the next field when it wraps.
- R4: The day of the week counts 1 to 7 and wraps to 1. It advances together with the date at the hour wrap.
- R5: The date wraps to 01 after the last day of the month, and then the month advances. Months have 31 or 30 days. February has 29 days when the year value is divisible by 4, otherwise 28. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R6: Address 0 is the control word, with bit 7 as write-freeze and bit 6 as read-freeze. Addresses 1 to 7 hold seconds, minutes, hours, day, date, month and year. Valid widths are 7, 7, 6, 3, 6, 5 and 8 bits. Unused bits, including control bits 5..0, read as 0.
- R7: A control write that sets read-freeze from TRACK captures the current count. The visible registers then stay unchanged while ticks keep advancing the counters.
- R8: After every freeze bit has cleared, the visible registers keep their held values until the next tick. After that they follow the counters again.
- R9: While write-freeze is set, the visible registers ignore ticks and accept writes. Outside write-freeze, writes to addresses 1 to 7 leave the visible time unchanged; only the oscillator bit is taken.
- R10: A control write that clears write-freeze loads every visible value into the counters on that clock edge. Counting then resumes from the loaded time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 = control, 1..7 = time fields) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |

## Verification
The hardest cases to reach are the cascaded rollovers. A date wrap at the end of February in a leap year, or a year wrap from 99 to 00, takes millions of ticks from the reset time. The bench avoids this by using write-freeze and commit to load 23:59:59 on the last day of every month, over a set of leap, non-leap and end-of-century years. It then applies one tick and compares the result with a calendar model written in binary. The freeze cases run ticks while the hold is active. They check that the held values are still present after the bit clears and before the next tick, and that the new count appears after that tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DW      = 8;
    localparam int FLD     = 7;
    localparam int ADDR_W  = 3;
    localparam int WR_BIT  = 7;
    localparam int RD_BIT  = 6;
    localparam int OSC_BIT = 7;

    localparam int IDX_SEC   = 0;
    localparam int IDX_MIN   = 1;
    localparam int IDX_HOUR  = 2;
    localparam int IDX_DOW   = 3;
    localparam int IDX_DATE  = 4;
    localparam int IDX_MONTH = 5;
    localparam int IDX_YEAR  = 6;

    typedef logic [FLD-1:0][DW-1:0] tvec_t;

    typedef enum logic [1:0] {
        MS_TRACK   = 2'd0,
        MS_RD_HOLD = 2'd1,
        MS_WR_HOLD = 2'd2,
        MS_RESYNC  = 2'd3
    } mir_state_e;

    function automatic logic [DW-1:0] field_mask(input int f);
        case (f)
            IDX_SEC:   return 8'h7F;
            IDX_MIN:   return 8'h7F;
            IDX_HOUR:  return 8'h3F;
            IDX_DOW:   return 8'h07;
            IDX_DATE:  return 8'h3F;
            IDX_MONTH: return 8'h1F;
            default:   return 8'hFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] field_lo(input int f);
        case (f)
            IDX_DOW, IDX_DATE, IDX_MONTH: return 8'h01;
            default:                      return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] field_hi(input int f);
        case (f)
            IDX_SEC, IDX_MIN: return 8'h59;
            IDX_HOUR:         return 8'h23;
            IDX_DOW:          return 8'h07;
            IDX_DATE:         return 8'h31;
            IDX_MONTH:        return 8'h12;
            default:          return 8'h99;
        endcase
    endfunction

    // Field whose wrap steps field f; the seconds field is stepped by the tick.
    function automatic int step_src(input int f);
        case (f)
            IDX_MIN:              return IDX_SEC;
            IDX_HOUR:             return IDX_MIN;
            IDX_DOW, IDX_DATE:    return IDX_HOUR;
            IDX_MONTH:            return IDX_DATE;
            IDX_YEAR:             return IDX_MONTH;
            default:              return 0;
        endcase
    endfunction

    function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [DW-1:0] last_day(input logic [DW-1:0] mon,
                                               input logic [DW-1:0] yr);
        int mb;
        int yb;
        mb = int'(mon[7:4]) * 10 + int'(mon[3:0]);
        yb = int'(yr[7:4]) * 10 + int'(yr[3:0]);
        if (mb == 2)
            return ((yb % 4) == 0) ? 8'h29 : 8'h28;
        else if (mb == 4 || mb == 6 || mb == 9 || mb == 11)
            return 8'h30;
        else
            return 8'h31;
    endfunction

endpackage

// File: rtl/rtc_field.sv
module rtc_field
    import rtc_pkg::*;
#(
    parameter logic [DW-1:0] RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic [DW-1:0] val,
    output logic          wrap
);

    logic at_top;

    assign at_top = (val >= hi);
    assign wrap   = step && at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= RST;
        else if (load)
            val <= load_val;
        else if (step)
            val <= at_top ? lo : bcd_inc(val);
    end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  osc_we,
    input  logic  osc_val,
    input  logic  load,
    input  tvec_t load_val,
    output tvec_t cnt,
    output logic  osc_stop
);

    logic           adv;
    logic [FLD-1:0] stp;
    logic [FLD-1:0] wrp;
    tvec_t          lo;
    tvec_t          hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            osc_stop <= 1'b1;
        else if (osc_we)
            osc_stop <= osc_val;
    end

    assign adv = tick && !osc_stop;

    for (genvar f = 0; f < FLD; f++) begin : g_fld
        localparam int SRC = step_src(f);

        if (f == IDX_SEC) begin : g_first
            assign stp[f] = adv;
        end else begin : g_chain
            assign stp[f] = wrp[SRC] && !load;
        end

        if (f == IDX_DATE) begin : g_date_hi
            assign hi[f] = last_day(cnt[IDX_MONTH], cnt[IDX_YEAR]);
        end else begin : g_const_hi
            assign hi[f] = field_hi(f);
        end

        assign lo[f] = field_lo(f);

        rtc_field #(
            .RST (field_lo(f))
        ) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (stp[f]),
            .load     (load),
            .load_val (load_val[f] & field_mask(f)),
            .lo       (lo[f]),
            .hi       (hi[f]),
            .val      (cnt[f]),
            .wrap     (wrp[f])
        );
    end

endmodule

// File: rtl/rtc_mirror.sv
module rtc_mirror
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctrl_we,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_idx,
    input  logic [DW-1:0]     wdata,
    input  tvec_t             cnt,
    output tvec_t             vis,
    output logic              load,
    output mir_state_e        state
);

    mir_state_e state_nxt;
    logic       cap;
    logic       vis_we;
    logic       new_wr;
    logic       new_rd;

    assign new_wr = wdata[WR_BIT];
    assign new_rd = wdata[RD_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= MS_TRACK;
        else
            state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            MS_TRACK: begin
                if (ctrl_we && new_wr)
                    state_nxt = MS_WR_HOLD;
                else if (ctrl_we && new_rd)
                    state_nxt = MS_RD_HOLD;
            end
            MS_RD_HOLD: begin
                if (ctrl_we && new_wr)
                    state_nxt = MS_WR_HOLD;
                else if (ctrl_we && !new_rd)
                    state_nxt = MS_RESYNC;
            end
            MS_WR_HOLD: begin
                if (ctrl_we && !new_wr)
                    state_nxt = new_rd ? MS_RD_HOLD : MS_RESYNC;
            end
            MS_RESYNC: begin
                if (ctrl_we && new_wr)
                    state_nxt = MS_WR_HOLD;
                else if (ctrl_we && new_rd)
                    state_nxt = MS_RD_HOLD;
                else if (tick)
                    state_nxt = MS_TRACK;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cap    = 1'b0;
        load   = 1'b0;
        vis_we = 1'b0;
        unique case (state)
            MS_TRACK:   cap = 1'b1;
            MS_RD_HOLD: cap = 1'b0;
            MS_WR_HOLD: begin
                load   = ctrl_we && !new_wr;
                vis_we = reg_we;
            end
            MS_RESYNC:  cap = tick || (ctrl_we && (new_wr || new_rd));
        endcase
    end

    // Visible register set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < FLD; f++)
                vis[f] <= field_lo(f);
        end else if (cap) begin
            vis <= cnt;
        end else if (vis_we) begin
            for (int f = 0; f < FLD; f++)
                if (reg_idx == ADDR_W'(f))
                    vis[f] <= wdata & field_mask(f);
        end
    end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);

    logic              sel_ctrl;
    logic              ctrl_we;
    logic              reg_we;
    logic              osc_we;
    logic [ADDR_W-1:0] idx;
    logic              wr_halt_q;
    logic              rd_halt_q;
    logic              osc_stop;
    logic              cnt_load;
    tvec_t             cnt;
    tvec_t             vis;
    mir_state_e        mir_state;

    assign sel_ctrl = (bus_addr == '0);
    assign idx      = bus_addr - ADDR_W'(1);
    assign ctrl_we  = bus_we && sel_ctrl;
    assign reg_we   = bus_we && !sel_ctrl;
    assign osc_we   = bus_we && (bus_addr == ADDR_W'(IDX_SEC + 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_halt_q <= 1'b0;
            rd_halt_q <= 1'b0;
        end else if (ctrl_we) begin
            wr_halt_q <= bus_wdata[WR_BIT];
            rd_halt_q <= bus_wdata[RD_BIT];
        end
    end

    rtc_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .osc_we   (osc_we),
        .osc_val  (bus_wdata[OSC_BIT]),
        .load     (cnt_load),
        .load_val (vis),
        .cnt      (cnt),
        .osc_stop (osc_stop)
    );

    rtc_mirror u_mir (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .ctrl_we (ctrl_we),
        .reg_we  (reg_we),
        .reg_idx (idx),
        .wdata   (bus_wdata),
        .cnt     (cnt),
        .vis     (vis),
        .load    (cnt_load),
        .state   (mir_state)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[WR_BIT] = wr_halt_q;
            bus_rdata[RD_BIT] = rd_halt_q;
        end else begin
            for (int f = 0; f < FLD; f++)
                if (idx == ADDR_W'(f))
                    bus_rdata = vis[f] & field_mask(f);
            if (idx == ADDR_W'(IDX_SEC))
                bus_rdata[OSC_BIT] = osc_stop;
        end
    end

endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       osc_stop,
    input logic       cnt_load,
    input mir_state_e mir_state,
    input tvec_t      cnt,
    input tvec_t      vis
);

    AST_OSC_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !cnt_load) |=> $stable(cnt)); // R2

    AST_READ_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_state == MS_RD_HOLD) |=> $stable(vis)); // R7

    AST_TRACK_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_state == MS_TRACK) |=> (vis == $past(cnt))); // R8

    AST_COMMIT_LOADS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt == $past(vis))); // R10

endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_stop  (osc_stop),
    .cnt_load  (cnt_load),
    .mir_state (mir_state),
    .cnt       (cnt),
    .vis       (vis)
);

// File: tb/rtc_bcd_core_test.sv
`timescale 1ns/1ps
module rtc_bcd_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    int m_s, m_m, m_h, m_dw, m_dt, m_mo, m_yr;
    bit m_osc;

    always #2.5 clk = ~clk;

    rtc_bcd_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 8'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse;
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic m_adv;
        if (m_osc) return;
        m_s++;
        if (m_s == 60) begin
            m_s = 0; m_m++;
            if (m_m == 60) begin
                m_m = 0; m_h++;
                if (m_h == 24) begin
                    m_h = 0;
                    m_dw = (m_dw == 7) ? 1 : m_dw + 1;
                    m_dt++;
                    if (m_dt > dim(m_mo, m_yr)) begin
                        m_dt = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1;
                            m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk_all(input string tag);
        logic [7:0] d;
        rd(3'd1, d); chk({tag, " sec"},   d, {m_osc, bcd(m_s)[6:0]});
        rd(3'd2, d); chk({tag, " min"},   d, bcd(m_m));
        rd(3'd3, d); chk({tag, " hour"},  d, bcd(m_h));
        rd(3'd4, d); chk({tag, " dow"},   d, bcd(m_dw));
        rd(3'd5, d); chk({tag, " date"},  d, bcd(m_dt));
        rd(3'd6, d); chk({tag, " month"}, d, bcd(m_mo));
        rd(3'd7, d); chk({tag, " year"},  d, bcd(m_yr));
    endtask

    // Load through write-freeze and commit (R9, R10)
    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int dt, input int mo, input int yr);
        wr(3'd0, 8'h80);
        wr(3'd1, bcd(s)); wr(3'd2, bcd(mi)); wr(3'd3, bcd(h));
        wr(3'd4, bcd(dw)); wr(3'd5, bcd(dt)); wr(3'd6, bcd(mo));
        wr(3'd7, bcd(yr));
        wr(3'd0, 8'h00);
        m_s = s; m_m = mi; m_h = h; m_dw = dw; m_dt = dt; m_mo = mo; m_yr = yr;
        m_osc = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] snap [7];
        int yrs [7] = '{0, 1, 2, 3, 4, 96, 99};

        m_s = 0; m_m = 0; m_h = 0; m_dw = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_osc = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
        chk_all("R1 reset");

        // R2 ticks ignored while oscillator stopped
        repeat (3) begin pulse(); m_adv(); end
        chk_all("R2 stopped");

        // R9 writes outside write-freeze ignored; R2 osc bit taken
        wr(3'd2, 8'h33);
        wr(3'd1, 8'h45);
        m_osc = 1'b0;
        @(negedge clk);
        chk_all("R9 ignored write");
        pulse(); m_adv();
        chk_all("R2 running");

        // R6 unused bits read 0 (inside write-freeze)
        wr(3'd0, 8'hFF);
        rd(3'd0, d); chk("R6 ctrl bits", d, 8'hC0);
        wr(3'd3, 8'hFF); rd(3'd3, d); chk("R6 hour mask", d, 8'h3F);
        wr(3'd4, 8'hFF); rd(3'd4, d); chk("R6 dow mask", d, 8'h07);
        wr(3'd6, 8'hFF); rd(3'd6, d); chk("R6 month mask", d, 8'h1F);
        wr(3'd5, 8'hFF); rd(3'd5, d); chk("R6 date mask", d, 8'h3F);

        // R9 write-freeze holds visible set against ticks
        wr(3'd1, 8'h12);
        pulse();
        rd(3'd1, d); chk("R9 frozen sec", d, 8'h12);
        set_time(0, 0, 0, 1, 1, 1, 0);
        chk_all("R10 commit");

        // R3 second/minute/hour carry sweep
        set_time(30, 58, 22, 3, 10, 5, 21);
        for (int i = 0; i < 100; i++) begin
            pulse(); m_adv();
            chk_all("R3 sweep");
        end
        set_time(59, 59, 23, 2, 14, 7, 50);
        pulse(); m_adv();
        chk_all("R3 R4 day carry");

        // R4 R5 month ends across leap and non-leap years
        for (int yi = 0; yi < 7; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                set_time(59, 59, 23, 7, dim(mo, yrs[yi]), mo, yrs[yi]);
                pulse(); m_adv();
                chk_all("R5 month end");
            end
        end
        // R5 Feb 28 in leap year goes to 29
        set_time(59, 59, 23, 4, 28, 2, 24);
        pulse(); m_adv();
        chk_all("R5 leap feb28");

        // R7 read-freeze captures and holds
        set_time(10, 20, 8, 5, 3, 3, 33);
        pulse(); m_adv();
        wr(3'd0, 8'h40);
        rd(3'd0, d); chk("R7 ctrl", d, 8'h40);
        rd(3'd1, snap[0]); rd(3'd2, snap[1]);
        chk("R7 capture sec", snap[0], bcd(m_s));
        repeat (3) begin pulse(); m_adv(); end
        rd(3'd1, d); chk("R7 held sec", d, snap[0]);
        rd(3'd2, d); chk("R7 held min", d, snap[1]);

        // R8 held until next tick, then follows
        wr(3'd0, 8'h00);
        @(negedge clk);
        rd(3'd1, d); chk("R8 still held", d, snap[0]);
        pulse(); m_adv();
        chk_all("R8 resumed");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule